// File: doc/BRIEF.md
# Per-Event Hit Buffer Organizer

This block collects the full-resolution detector hits of one event as they arrive, one hit per cycle, each tagged with a layer number and a 16-bit position. From every hit it derives a coarse super-strip identifier by shifting the position right by a per-hit amount. It files the hit under that (layer, super-strip) pair. The first time a super-strip shows up on a layer during the event, that super-strip is forwarded to a downstream pattern matcher. Later hits in the same super-strip are stored but not forwarded again.

A hit flagged as the last of the event freezes the buffer. From then on, the block answers retrieval requests naming a (layer, super-strip) pair. For each request it streams back every stored full-resolution position filed under that pair, one per cycle and in arrival order. The final beat is flagged. A request that matches nothing gets exactly one empty beat. A clear pulse discards the whole event in one cycle, so the next event can be loaded.

Storage is a per-layer directory of super-strip slots. Each slot holds a valid bit, a tag, and head and tail pointers into a shared hit memory whose entries are chained by next pointers. Both the slot count per layer and the hit memory depth are parameters. Hits that do not fit are dropped.

Top module: `hit_buffer_org`

## Requirements
- R1: While reset is asserted, and after it is released, `ss_valid_o`, `rsp_valid_o` and `req_ready_o` are all 0 until a hit or request changes them.
- R2: An accepted hit whose super-strip is new to its layer for this event produces `ss_valid_o`=1 in the cycle after the accepting edge. In that cycle `ss_o` = `hit_pos_i >> shift_i` and `ss_layer_o` = `hit_layer_i`.
- R3: A hit whose super-strip has already been seen on the same layer in this event produces no super-strip output. The same super-strip value on a different layer is still forwarded.
- R4: A hit accepted with `hit_last_i`=1 is stored and freezes the buffer. `req_ready_o` goes high in the following cycle. Hits offered while frozen are neither forwarded nor stored, and so cannot be retrieved.
- R5: An accepted request for a stored (layer, super-strip) returns its positions one per cycle, in arrival order. The first beat appears in the cycle after acceptance. `rsp_last_o`=1 marks the final beat, and `req_ready_o` stays low until that final beat.
- R6: An accepted request that matches no stored entry returns exactly one beat, with `rsp_valid_o`=1, `rsp_empty_o`=1 and `rsp_last_o`=1.
- R7: A `clear_i` pulse empties the buffer and unfreezes it. In the following cycle `rsp_valid_o`, `req_ready_o` and `ss_valid_o` are 0. A response in progress is abandoned, and a hit offered in the same cycle as the clear is dropped. After the clear, previously seen super-strips are forwarded again.
- R8: Once a layer holds SLOTS distinct super-strips, a hit with a new super-strip on that layer is dropped and not forwarded. Once DEPTH hits are stored in total, every further hit is dropped.
- R9: Before the buffer is frozen, `req_ready_o` is 0. A request held during that time is not answered until it is accepted after the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_i | input | SHIFT_W | Right shift applied to the hit position to form its super-strip |
| clear_i | input | 1 | Discard the stored event and unfreeze |
| hit_valid_i | input | 1 | Hit offered this cycle |
| hit_layer_i | input | LW | Layer of the hit |
| hit_pos_i | input | POS_W | Full-resolution hit position |
| hit_last_i | input | 1 | This hit closes the event |
| ss_valid_o | output | 1 | New super-strip forwarded this cycle |
| ss_layer_o | output | LW | Layer of the forwarded super-strip |
| ss_o | output | POS_W | Forwarded super-strip value |
| req_valid_i | input | 1 | Retrieval request offered |
| req_layer_i | input | LW | Requested layer |
| req_ss_i | input | POS_W | Requested super-strip |
| req_ready_o | output | 1 | Request accepted on this edge if offered |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_pos_o | output | POS_W | Returned full-resolution position |
| rsp_last_o | output | 1 | Final beat of the response |
| rsp_empty_o | output | 1 | Request matched nothing |

## Verification
Two pairs of functions can collide in a single cycle.

The first is the closing hit of an event arriving together with a retrieval request. The bench holds a request high before the freeze and through the cycle that carries the closing hit. It then checks three things: no beat appears early, `req_ready_o` rises only in the cycle after the closing hit, and the answer includes that closing hit.

The second is a clear landing while a response stream is running and a fresh hit is offered. The bench raises the clear on the first beat of a four-beat answer, together with a hit. In the next cycle it checks that the stream has stopped, that the buffer is no longer ready, and that the hit left no trace when its super-strip is later requested.

// File: rtl/hbo_pkg.sv
package hbo_pkg;

  // Retrieval engine state: idle waits for a request, run walks a hit chain.
  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_state_e;

endpackage

// File: rtl/hbo_dir.sv
// Super-strip directory: SLOTS entries per layer, each holding a valid bit,
// a tag and head/tail pointers into the hit memory. NS must be a power of two.
module hbo_dir #(
  parameter int NL    = 8,
  parameter int NS    = 16,
  parameter int SS_W  = 16,
  parameter int PTR_W = 8,
  localparam int LW   = (NL > 1) ? $clog2(NL) : 1,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  // write side: lookup, then allocate or append
  input  logic [LW-1:0]    a_layer_i,
  input  logic [SS_W-1:0]  a_ss_i,
  output logic             a_hit_o,
  output logic [PTR_W-1:0] a_tail_o,
  output logic             a_free_o,
  input  logic             alloc_i,
  input  logic             append_i,
  input  logic [PTR_W-1:0] a_ptr_i,
  // read side: lookup for retrieval
  input  logic [LW-1:0]    b_layer_i,
  input  logic [SS_W-1:0]  b_ss_i,
  output logic             b_hit_o,
  output logic [PTR_W-1:0] b_head_o,
  output logic [PTR_W-1:0] b_tail_o
);

  localparam int GW = LW + SW;
  localparam int NE = 1 << GW;

  logic [NE-1:0]    vld_q;
  logic [SS_W-1:0]  tag_q  [NE];
  logic [PTR_W-1:0] head_q [NE];
  logic [PTR_W-1:0] tail_q [NE];

  logic [NS-1:0] a_match, a_vacant, b_match;
  logic [SW-1:0] a_slot, a_fslot, b_slot;
  logic [GW-1:0] alloc_idx, app_idx, b_idx;

  // per-slot comparators for both lookup ports
  for (genvar s = 0; s < NS; s++) begin : g_cmp
    localparam logic [SW-1:0] SI = SW'(s);
    assign a_match[s]  = vld_q[{a_layer_i, SI}] && (tag_q[{a_layer_i, SI}] == a_ss_i);
    assign a_vacant[s] = !vld_q[{a_layer_i, SI}];
    assign b_match[s]  = vld_q[{b_layer_i, SI}] && (tag_q[{b_layer_i, SI}] == b_ss_i);
  end

  // lowest-numbered slot wins in each encoder
  always_comb begin
    a_slot  = '0;
    a_fslot = '0;
    b_slot  = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (a_match[s])  a_slot  = SW'(s);
      if (a_vacant[s]) a_fslot = SW'(s);
      if (b_match[s])  b_slot  = SW'(s);
    end
  end

  assign a_hit_o   = |a_match;
  assign a_free_o  = |a_vacant;
  assign b_hit_o   = |b_match;
  assign alloc_idx = {a_layer_i, a_fslot};
  assign app_idx   = {a_layer_i, a_slot};
  assign b_idx     = {b_layer_i, b_slot};
  assign a_tail_o  = tail_q[app_idx];
  assign b_head_o  = head_q[b_idx];
  assign b_tail_o  = tail_q[b_idx];

  // valid bits: whole directory emptied in one cycle by clr_i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (alloc_i) begin
      vld_q[alloc_idx] <= 1'b1;
    end
  end

  // slot payload, written only under its enables
  always_ff @(posedge clk) begin
    if (alloc_i) begin
      tag_q[alloc_idx]  <= a_ss_i;
      head_q[alloc_idx] <= a_ptr_i;
      tail_q[alloc_idx] <= a_ptr_i;
    end else if (append_i) begin
      tail_q[app_idx] <= a_ptr_i;
    end
  end

endmodule

// File: rtl/hbo_hit_ram.sv
// Shared hit memory: a position word and a next-hit link per entry.
module hbo_hit_ram #(
  parameter int DEPTH = 256,
  parameter int POS_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [POS_W-1:0] wpos_i,
  input  logic             le_i,
  input  logic [PTR_W-1:0] laddr_i,
  input  logic [PTR_W-1:0] lnext_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [POS_W-1:0] rpos_o,
  output logic [PTR_W-1:0] rnext_o
);

  logic [POS_W-1:0] pos_mem [DEPTH];
  logic [PTR_W-1:0] nxt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) pos_mem[waddr_i] <= wpos_i;
    if (le_i) nxt_mem[laddr_i] <= lnext_i;
  end

  assign rpos_o  = pos_mem[raddr_i];
  assign rnext_o = nxt_mem[raddr_i];

endmodule

// File: rtl/hbo_fetch.sv
// Retrieval engine: turns one request into a stream of response beats.
module hbo_fetch #(
  parameter int POS_W = 16,
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             frozen_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             lk_hit_i,
  input  logic [PTR_W-1:0] lk_head_i,
  input  logic [PTR_W-1:0] lk_tail_i,
  output logic [PTR_W-1:0] raddr_o,
  input  logic [POS_W-1:0] rpos_i,
  input  logic [PTR_W-1:0] rnext_i,
  output logic             rsp_valid_o,
  output logic [POS_W-1:0] rsp_pos_o,
  output logic             rsp_last_o,
  output logic             rsp_empty_o
);

  import hbo_pkg::*;

  fetch_state_e     st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, end_q, end_d;
  logic             v_q, v_d, last_q, last_d, empty_q, empty_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             accept;

  assign req_ready_o = frozen_i && (st_q == FETCH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign raddr_o     = (st_q == FETCH_RUN) ? ptr_q : lk_head_i;

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    end_d   = end_q;
    pos_d   = pos_q;
    v_d     = 1'b0;
    last_d  = 1'b0;
    empty_d = 1'b0;
    if (clr_i) begin
      st_d = FETCH_IDLE;
    end else if (accept) begin
      v_d = 1'b1;
      if (lk_hit_i) begin
        pos_d  = rpos_i;
        last_d = (lk_head_i == lk_tail_i);
        st_d   = last_d ? FETCH_IDLE : FETCH_RUN;
        ptr_d  = rnext_i;
        end_d  = lk_tail_i;
      end else begin
        pos_d   = '0;
        last_d  = 1'b1;
        empty_d = 1'b1;
        st_d    = FETCH_IDLE;
      end
    end else if (st_q == FETCH_RUN) begin
      v_d    = 1'b1;
      pos_d  = rpos_i;
      last_d = (ptr_q == end_q);
      st_d   = last_d ? FETCH_IDLE : FETCH_RUN;
      ptr_d  = rnext_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FETCH_IDLE;
      ptr_q   <= '0;
      end_q   <= '0;
      pos_q   <= '0;
      v_q     <= 1'b0;
      last_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      end_q   <= end_d;
      pos_q   <= pos_d;
      v_q     <= v_d;
      last_q  <= last_d;
      empty_q <= empty_d;
    end
  end

  assign rsp_valid_o = v_q;
  assign rsp_pos_o   = pos_q;
  assign rsp_last_o  = last_q;
  assign rsp_empty_o = empty_q;

endmodule

// File: rtl/hit_buffer_org.sv
// Per-event hit buffer organizer: files hits by (layer, super-strip),
// forwards each new super-strip once, and serves retrieval after freeze.
module hit_buffer_org #(
  parameter int NLAYER  = 8,
  parameter int POS_W   = 16,
  parameter int SHIFT_W = 3,
  parameter int SLOTS   = 16,   // per layer, power of two
  parameter int DEPTH   = 256,  // total hits, power of two
  localparam int LW     = (NLAYER > 1) ? $clog2(NLAYER) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               clear_i,
  input  logic               hit_valid_i,
  input  logic [LW-1:0]      hit_layer_i,
  input  logic [POS_W-1:0]   hit_pos_i,
  input  logic               hit_last_i,
  output logic               ss_valid_o,
  output logic [LW-1:0]      ss_layer_o,
  output logic [POS_W-1:0]   ss_o,
  input  logic               req_valid_i,
  input  logic [LW-1:0]      req_layer_i,
  input  logic [POS_W-1:0]   req_ss_i,
  output logic               req_ready_o,
  output logic               rsp_valid_o,
  output logic [POS_W-1:0]   rsp_pos_o,
  output logic               rsp_last_o,
  output logic               rsp_empty_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int WP_W  = PTR_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [POS_W-1:0] coarse;
  logic             take, full, store_new, store_app;
  logic             a_hit, a_free, b_hit;
  logic [PTR_W-1:0] a_tail, b_head, b_tail, raddr, rnext;
  logic [POS_W-1:0] rpos;
  logic             frozen_q, frozen_d;
  logic [WP_W-1:0]  wptr_q, wptr_d;
  logic             ssv_q, ssv_d;
  logic [LW-1:0]    ssl_q;
  logic [POS_W-1:0] ss_q;

  assign coarse    = hit_pos_i >> shift_i;
  assign full      = (wptr_q == WP_W'(DEPTH));
  assign take      = hit_valid_i && !frozen_q && !clear_i;
  assign store_app = take && !full && a_hit;
  assign store_new = take && !full && !a_hit && a_free;

  always_comb begin
    frozen_d = frozen_q;
    wptr_d   = wptr_q;
    ssv_d    = store_new;
    if (clear_i) begin
      frozen_d = 1'b0;
      wptr_d   = '0;
    end else begin
      if (take && hit_last_i)       frozen_d = 1'b1;
      if (store_new || store_app)   wptr_d   = wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      wptr_q   <= '0;
      ssv_q    <= 1'b0;
    end else begin
      frozen_q <= frozen_d;
      wptr_q   <= wptr_d;
      ssv_q    <= ssv_d;
    end
  end

  // forwarded super-strip payload, loaded only when a new one is filed
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ssl_q <= '0;
      ss_q  <= '0;
    end else if (store_new) begin
      ssl_q <= hit_layer_i;
      ss_q  <= coarse;
    end
  end

  assign ss_valid_o = ssv_q;
  assign ss_layer_o = ssl_q;
  assign ss_o       = ss_q;

  hbo_dir #(
    .NL(NLAYER), .NS(SLOTS), .SS_W(POS_W), .PTR_W(PTR_W)
  ) u_dir (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr_i     (clear_i),
    .a_layer_i (hit_layer_i),
    .a_ss_i    (coarse),
    .a_hit_o   (a_hit),
    .a_tail_o  (a_tail),
    .a_free_o  (a_free),
    .alloc_i   (store_new),
    .append_i  (store_app),
    .a_ptr_i   (wptr_q[PTR_W-1:0]),
    .b_layer_i (req_layer_i),
    .b_ss_i    (req_ss_i),
    .b_hit_o   (b_hit),
    .b_head_o  (b_head),
    .b_tail_o  (b_tail)
  );

  hbo_hit_ram #(
    .DEPTH(DEPTH), .POS_W(POS_W)
  ) u_ram (
    .clk     (clk),
    .we_i    (store_new || store_app),
    .waddr_i (wptr_q[PTR_W-1:0]),
    .wpos_i  (hit_pos_i),
    .le_i    (store_app),
    .laddr_i (a_tail),
    .lnext_i (wptr_q[PTR_W-1:0]),
    .raddr_i (raddr),
    .rpos_o  (rpos),
    .rnext_o (rnext)
  );

  hbo_fetch #(
    .POS_W(POS_W), .PTR_W(PTR_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_ni),
    .clr_i       (clear_i),
    .frozen_i    (frozen_q),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .lk_hit_i    (b_hit),
    .lk_head_i   (b_head),
    .lk_tail_i   (b_tail),
    .raddr_o     (raddr),
    .rpos_i      (rpos),
    .rnext_i     (rnext),
    .rsp_valid_o (rsp_valid_o),
    .rsp_pos_o   (rsp_pos_o),
    .rsp_last_o  (rsp_last_o),
    .rsp_empty_o (rsp_empty_o)
  );

endmodule

// File: rtl/hbo_chk.sv
module hbo_chk #(
  parameter int POS_W   = 16,
  parameter int LW      = 3,
  parameter int SHIFT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SHIFT_W-1:0] shift_i,
  input logic               clear_i,
  input logic               hit_valid_i,
  input logic [LW-1:0]      hit_layer_i,
  input logic [POS_W-1:0]   hit_pos_i,
  input logic               ss_valid_o,
  input logic [LW-1:0]      ss_layer_o,
  input logic [POS_W-1:0]   ss_o,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_last_o,
  input logic               rsp_empty_o
);

  // R2
  ss_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_valid_o |-> ($past(hit_valid_i) && ss_layer_o == $past(hit_layer_i)
                    && ss_o == ($past(hit_pos_i) >> $past(shift_i))));

  // R4
  frozen_no_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |=> !ss_valid_o);

  // R5
  stream_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_last_o && !clear_i) |=> rsp_valid_o);

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_last_o) |-> !req_ready_o);

  // R6
  empty_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_empty_o |-> (rsp_valid_o && rsp_last_o));

  // R7
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!rsp_valid_o && !req_ready_o && !ss_valid_o));

endmodule

bind hit_buffer_org hbo_chk #(.POS_W(POS_W), .LW(LW), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/tb_hit_buffer_org.sv
module tb_hit_buffer_org;

  logic        clk, rst_n, clear_i, hit_valid_i, hit_last_i, req_valid_i;
  logic [2:0]  shift_i, hit_layer_i, req_layer_i;
  logic [15:0] hit_pos_i, req_ss_i;
  logic        ss_valid_o, req_ready_o, rsp_valid_o, rsp_last_o, rsp_empty_o;
  logic [2:0]  ss_layer_o;
  logic [15:0] ss_o, rsp_pos_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_pos [256];

  hit_buffer_org dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: layer[38:36] pos[35:20] shift[19:17] emit[16] ss[15:0]
  localparam logic [38:0] VEC [10] = '{
    {3'd0, 16'h0010, 3'd2, 1'b1, 16'h0004},
    {3'd0, 16'h0013, 3'd2, 1'b0, 16'h0004},
    {3'd1, 16'h0010, 3'd2, 1'b1, 16'h0004},
    {3'd0, 16'h0014, 3'd2, 1'b1, 16'h0005},
    {3'd0, 16'h0011, 3'd2, 1'b0, 16'h0004},
    {3'd7, 16'hFFFF, 3'd7, 1'b1, 16'h01FF},
    {3'd7, 16'hFF80, 3'd7, 1'b0, 16'h01FF},
    {3'd3, 16'h1234, 3'd0, 1'b1, 16'h1234},
    {3'd3, 16'h1234, 3'd0, 1'b0, 16'h1234},
    {3'd2, 16'h8000, 3'd4, 1'b1, 16'h0800}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; checks the forwarded super-strip afterwards
  task automatic send_hit(input logic [2:0] l, input logic [15:0] p,
                          input logic [2:0] sh, input bit last, input bit emit,
                          input logic [15:0] ess, input string req);
    hit_valid_i = 1'b1; hit_layer_i = l; hit_pos_i = p;
    shift_i = sh; hit_last_i = last;
    @(posedge clk); @(negedge clk);
    hit_valid_i = 1'b0; hit_last_i = 1'b0;
    chk(ss_valid_o == emit, req, "ss_valid", int'(ss_valid_o), int'(emit));
    if (emit) begin
      chk(ss_o == ess, req, "ss value", int'(ss_o), int'(ess));
      chk(ss_layer_o == l, req, "ss layer", int'(ss_layer_o), int'(l));
    end
  endtask

  // at a falling edge with the first beat visible; n==0 means empty answer
  task automatic collect(input int n, input string req);
    int got = 0;
    bit done = 1'b0;
    while (!done) begin
      if (!rsp_valid_o) begin
        chk(1'b0, req, "rsp_valid", 0, 1);
        done = 1'b1;
      end else if (n == 0) begin
        chk(rsp_empty_o && rsp_last_o, req, "empty beat",
            int'({rsp_empty_o, rsp_last_o}), 3);
        done = 1'b1;
      end else begin
        chk(!rsp_empty_o, req, "empty flag", int'(rsp_empty_o), 0);
        if (got < n)
          chk(rsp_pos_o == exp_pos[got], req, "position",
              int'(rsp_pos_o), int'(exp_pos[got]));
        got++;
        done = rsp_last_o || (got > n);
        if (!done) @(negedge clk);
      end
    end
    if (n > 0) chk(got == n, req, "beat count", got, n);
  endtask

  task automatic req_wait(input int n, input string req);
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    collect(n, req);
  endtask

  task automatic req_go(input logic [2:0] l, input logic [15:0] ss,
                        input int n, input string req);
    req_valid_i = 1'b1; req_layer_i = l; req_ss_i = ss;
    req_wait(n, req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; clear_i = 1'b0; hit_valid_i = 1'b0; hit_last_i = 1'b0;
    req_valid_i = 1'b0; shift_i = '0; hit_layer_i = '0; hit_pos_i = '0;
    req_layer_i = '0; req_ss_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!ss_valid_o && !rsp_valid_o && !req_ready_o, "R1", "outputs in reset",
        int'({ss_valid_o, rsp_valid_o, req_ready_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ss_valid_o && !rsp_valid_o && !req_ready_o, "R1", "outputs after reset",
        int'({ss_valid_o, rsp_valid_o, req_ready_o}), 0);

    // event 1: vector walk (R2 new, R3 repeats)
    for (int i = 0; i < 10; i++) begin
      send_hit(VEC[i][38:36], VEC[i][35:20], VEC[i][19:17], 1'b0,
               VEC[i][16], VEC[i][15:0], VEC[i][16] ? "R2" : "R3");
    end

    // R9: request held before freeze is not answered
    req_valid_i = 1'b1; req_layer_i = 3'd0; req_ss_i = 16'h0004;
    @(posedge clk); @(negedge clk);
    chk(!req_ready_o, "R9", "ready before freeze", int'(req_ready_o), 0);
    chk(!rsp_valid_o, "R9", "no early beat", int'(rsp_valid_o), 0);
    // closing hit in the same cycle as the pending request
    hit_valid_i = 1'b1; hit_layer_i = 3'd0; hit_pos_i = 16'h0012;
    shift_i = 3'd2; hit_last_i = 1'b1;
    @(posedge clk); @(negedge clk);
    hit_valid_i = 1'b0; hit_last_i = 1'b0;
    chk(!ss_valid_o, "R3", "closing duplicate", int'(ss_valid_o), 0);
    chk(req_ready_o, "R4", "ready after closing hit", int'(req_ready_o), 1);
    chk(!rsp_valid_o, "R9", "no beat before accept", int'(rsp_valid_o), 0);
    exp_pos[0] = 16'h0010; exp_pos[1] = 16'h0013;
    exp_pos[2] = 16'h0011; exp_pos[3] = 16'h0012;
    req_wait(4, "R5");

    // R4: hits while frozen are ignored
    send_hit(3'd0, 16'h0040, 3'd2, 1'b0, 1'b0, 16'h0, "R4");
    req_go(3'd0, 16'h0010, 0, "R4");
    exp_pos[0] = 16'hFFFF; exp_pos[1] = 16'hFF80;
    req_go(3'd7, 16'h01FF, 2, "R5");
    exp_pos[0] = 16'h1234; exp_pos[1] = 16'h1234;
    req_go(3'd3, 16'h1234, 2, "R5");
    exp_pos[0] = 16'h0010;
    req_go(3'd1, 16'h0004, 1, "R5");
    exp_pos[0] = 16'h8000;
    req_go(3'd2, 16'h0800, 1, "R5");
    req_go(3'd5, 16'h0004, 0, "R6");
    req_go(3'd0, 16'h0006, 0, "R6");

    // R7: clear on first beat of a stream, with a hit in the same cycle
    req_valid_i = 1'b1; req_layer_i = 3'd0; req_ss_i = 16'h0004;
    while (!req_ready_o) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    chk(rsp_valid_o && rsp_pos_o == 16'h0010, "R5", "first beat",
        int'(rsp_pos_o), 16'h0010);
    clear_i = 1'b1; hit_valid_i = 1'b1; hit_layer_i = 3'd5;
    hit_pos_i = 16'h0100; shift_i = 3'd2;
    @(posedge clk); @(negedge clk);
    clear_i = 1'b0; hit_valid_i = 1'b0;
    chk(!rsp_valid_o, "R7", "stream stopped", int'(rsp_valid_o), 0);
    chk(!req_ready_o, "R7", "unfrozen", int'(req_ready_o), 0);
    chk(!ss_valid_o, "R7", "hit with clear", int'(ss_valid_o), 0);

    // event 2: earlier super-strips forwarded again
    send_hit(3'd0, 16'h0010, 3'd2, 1'b0, 1'b1, 16'h0004, "R7");
    send_hit(3'd1, 16'h0020, 3'd2, 1'b1, 1'b1, 16'h0008, "R7");
    req_go(3'd5, 16'h0040, 0, "R7");
    exp_pos[0] = 16'h0010;
    req_go(3'd0, 16'h0004, 1, "R7");
    exp_pos[0] = 16'h0020;
    req_go(3'd1, 16'h0008, 1, "R4");

    clear_i = 1'b1;
    @(posedge clk); @(negedge clk);
    clear_i = 1'b0;
    chk(!req_ready_o, "R7", "ready after clear", int'(req_ready_o), 0);

    // event 3: capacity (R8)
    for (int i = 0; i < 16; i++)
      send_hit(3'd4, 16'(i), 3'd0, 1'b0, 1'b1, 16'(i), "R8");
    send_hit(3'd4, 16'd16, 3'd0, 1'b0, 1'b0, 16'h0, "R8");
    send_hit(3'd4, 16'd3, 3'd0, 1'b0, 1'b0, 16'h0, "R8");
    for (int k = 0; k < 239; k++)
      send_hit(3'd6, 16'(k), 3'd7, 1'b0, (k == 0) || (k == 128),
               (k < 128) ? 16'h0 : 16'h1, "R8");
    send_hit(3'd6, 16'h007F, 3'd7, 1'b0, 1'b0, 16'h0, "R8");
    send_hit(3'd5, 16'h0020, 3'd0, 1'b0, 1'b0, 16'h0, "R8");
    send_hit(3'd5, 16'h0021, 3'd0, 1'b1, 1'b0, 16'h0, "R8");
    for (int k = 0; k < 128; k++) exp_pos[k] = 16'(k);
    req_go(3'd6, 16'h0000, 128, "R8");
    for (int k = 0; k < 111; k++) exp_pos[k] = 16'(128 + k);
    req_go(3'd6, 16'h0001, 111, "R8");
    req_go(3'd4, 16'd16, 0, "R8");
    exp_pos[0] = 16'd3; exp_pos[1] = 16'd3;
    req_go(3'd4, 16'd3, 2, "R8");
    req_go(3'd5, 16'h0020, 0, "R8");

    summary();
    $finish;
  end

endmodule